// File: doc/BRIEF.md
# Hardware Data Stack

A dedicated data stack for a small processor core. It keeps 256 words of 16 bits in a local array and manages them with its own 8-bit pointer. The stack grows toward lower addresses. A push writes at the current pointer and then moves the pointer down by one. A pop reads the word one above the pointer and then moves the pointer up by one. The pointer can be observed but has no write path; only pushes, pops and reset change it.

The pointer is seen through a 16-bit status view. The lower byte of the view is the pointer. The upper byte is a bank byte that the processor supplies and the block only passes through. Reads from the array are synchronous, so popped data and every error indication appear in the cycle after the request.

Top module: `data_stack`

## Requirements
- R1: During and after reset the pointer is 0xFF, the stack is empty, `pop_data` is 0x0000, and `pop_valid`, `overflow`, `underflow` and `conflict` are low.
- R2: `stat_view` always equals `{bank_in, pointer}`: the bank byte sits in bits 15:8 and the pointer in bits 7:0. The bank byte passes through combinationally.
- R3: A push alone on a stack that is not full stores `push_data` at the current pointer. The pointer then reads one lower in the following cycle.
- R4: A pop alone on a stack that is not empty returns the word at pointer+1 on `pop_data`, with `pop_valid` high in the cycle after the request. The pointer reads one higher in that same cycle.
- R5: A push alone when 256 words are held raises `overflow` for exactly one cycle, in the cycle after the request. The pointer is unchanged and no stored word is altered.
- R6: A pop alone on an empty stack raises `underflow` for exactly one cycle, in the cycle after the request. The pointer is unchanged and `pop_valid` stays low.
- R7: Push and pop asserted together raise `conflict` for one cycle. Nothing is written, the pointer holds, `pop_valid` stays low, and `overflow` and `underflow` stay low.
- R8: The stack holds all 256 entries. After 256 pushes from empty, the pointer is back at 0xFF, and 256 pops return the words in reverse order of pushing.
- R9: With neither request asserted, the pointer and all outputs other than `stat_view`'s bank byte hold, and every pulse is low.
- R10: `pop_data` keeps the last successfully popped word until the next successful pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Push request |
| push_data | input | 16 | Word to push |
| pop | input | 1 | Pop request |
| pop_data | output | 16 | Popped word, registered |
| pop_valid | output | 1 | High the cycle after a successful pop |
| bank_in | input | 8 | Bank byte supplied by the processor |
| stat_view | output | 16 | Bank byte over pointer, read-only |
| overflow | output | 1 | Push-on-full pulse |
| underflow | output | 1 | Pop-on-empty pulse |
| conflict | output | 1 | Simultaneous push and pop pulse |

## Verification
The first pattern is a short interleaved sequence of pushes and pops. Its data values are distinct, so the pop data shows whether the read address is pointer+1 and not the pointer itself. The next pattern is a single request made on an empty stack and on a nearly empty one, which separates the underflow response from a normal pop. A request with both lines high, made mid-stack, checks that a conflict neither writes nor reads.

A full 256-deep fill followed by a full drain checks the wrap point, where full and empty share pointer 0xFF. The fill also includes a push made while the stack is full. The first pop afterwards shows whether that push was kept out of the array.

// File: rtl/data_stack_pkg.sv
package data_stack_pkg;
   typedef enum logic [2:0] {
      EV_IDLE,
      EV_PUSH,
      EV_POP,
      EV_OVF,
      EV_UNF,
      EV_CONF
   } stk_event_e;
endpackage

// File: rtl/data_stack_ptr.sv
module data_stack_ptr
   import data_stack_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] sp,
   output logic [PTR_W-1:0] wr_addr,
   output logic [PTR_W-1:0] rd_addr,
   output logic             wr_en,
   output logic             rd_en,
   output logic             ovf_q,
   output logic             unf_q,
   output logic             conf_q,
   output logic             valid_q
);
   localparam int CNT_W = PTR_W + 1;
   localparam int DEPTH = 1 << PTR_W;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count;
   logic             full, empty;
   stk_event_e       ev;

   assign full  = (count == CNT_FULL);
   assign empty = (count == '0);

   always_comb begin
      if (push && pop)  ev = EV_CONF;
      else if (push)    ev = full  ? EV_OVF : EV_PUSH;
      else if (pop)     ev = empty ? EV_UNF : EV_POP;
      else              ev = EV_IDLE;
   end

   assign wr_en   = (ev == EV_PUSH);
   assign rd_en   = (ev == EV_POP);
   assign wr_addr = sp;
   assign rd_addr = sp + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp      <= '1;
         count   <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
         conf_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         ovf_q   <= (ev == EV_OVF);
         unf_q   <= (ev == EV_UNF);
         conf_q  <= (ev == EV_CONF);
         valid_q <= (ev == EV_POP);
         if (ev == EV_PUSH) begin
            sp    <= sp - 1'b1;
            count <= count + 1'b1;
         end else if (ev == EV_POP) begin
            sp    <= sp + 1'b1;
            count <= count - 1'b1;
         end
      end
   end

   // R3
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !full) |=> (sp == $past(sp) - 1'b1));
   // R4
   pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (sp == $past(sp) + 1'b1) && valid_q);
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> $stable(sp) && ovf_q);
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> $stable(sp) && unf_q && !valid_q);
   // R7
   conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(sp) && conf_q && !valid_q);
   // R8
   ptr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty || full) |-> (sp == '1));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(sp) && $stable(count));
endmodule

// File: rtl/data_stack_store.sv
module data_stack_store #(
   parameter int DATA_W    = 16,
   parameter int PTR_W     = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << PTR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   generate
      if (HOLD_DATA) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_data <= '0;
            else if (rd_en) rd_data <= mem[rd_addr];
         end
      end else begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_en ? mem[rd_addr] : '0;
         end
      end
   endgenerate

   // R7
   no_rw_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
endmodule

// File: rtl/data_stack.sv
module data_stack #(
   parameter int DATA_W    = 16,
   parameter int PTR_W     = 8,
   parameter int BANK_W    = 8,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [DATA_W-1:0]       push_data,
   input  logic                    pop,
   output logic [DATA_W-1:0]       pop_data,
   output logic                    pop_valid,
   input  logic [BANK_W-1:0]       bank_in,
   output logic [BANK_W+PTR_W-1:0] stat_view,
   output logic                    overflow,
   output logic                    underflow,
   output logic                    conflict
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("data_stack: DATA_W must be positive");
      end
      if (PTR_W < 1 || PTR_W > 12) begin : g_bad_ptr
         $error("data_stack: PTR_W out of range 1..12");
      end
      if (BANK_W < 0) begin : g_bad_bank
         $error("data_stack: BANK_W must not be negative");
      end
   endgenerate

   logic [PTR_W-1:0] sp, wr_addr, rd_addr;
   logic             wr_en, rd_en;

   data_stack_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .pop     (pop),
      .sp      (sp),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .ovf_q   (overflow),
      .unf_q   (underflow),
      .conf_q  (conflict),
      .valid_q (pop_valid)
   );

   data_stack_store #(
      .DATA_W    (DATA_W),
      .PTR_W     (PTR_W),
      .HOLD_DATA (HOLD_DATA)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (push_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (pop_data)
   );

   assign stat_view = {bank_in, sp};

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({overflow, underflow, conflict, pop_valid}));
endmodule

// File: tb/data_stack_bench.sv
module data_stack_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        push, pop;
   logic [15:0] push_data;
   logic [15:0] pop_data;
   logic        pop_valid;
   logic [7:0]  bank_in;
   logic [15:0] stat_view;
   logic        overflow, underflow, conflict;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   data_stack u_data_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .pop_data  (pop_data),
      .pop_valid (pop_valid),
      .bank_in   (bank_in),
      .stat_view (stat_view),
      .overflow  (overflow),
      .underflow (underflow),
      .conflict  (conflict)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 50000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic p, input logic o, input logic [15:0] d);
      push = p; pop = o; push_data = d;
      @(negedge clk);
   endtask

   task automatic check_flags(input string tag, input logic [3:0] exp);
      check(tag, {28'd0, overflow, underflow, conflict, pop_valid}, {28'd0, exp});
   endtask

   // push, pop, data, exp_sp, {ovf,unf,conf,valid}, exp_pop_data
   localparam int VW = 46;
   localparam int NV = 10;
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 1'b1, 16'h0000, 8'hFF, 4'b0100, 16'h0000},
      {1'b1, 1'b0, 16'h1111, 8'hFE, 4'b0000, 16'h0000},
      {1'b1, 1'b0, 16'h2222, 8'hFD, 4'b0000, 16'h0000},
      {1'b1, 1'b1, 16'h9999, 8'hFD, 4'b0010, 16'h0000},
      {1'b0, 1'b1, 16'h0000, 8'hFE, 4'b0001, 16'h2222},
      {1'b1, 1'b0, 16'h3333, 8'hFD, 4'b0000, 16'h2222},
      {1'b0, 1'b1, 16'h0000, 8'hFE, 4'b0001, 16'h3333},
      {1'b0, 1'b1, 16'h0000, 8'hFF, 4'b0001, 16'h1111},
      {1'b0, 1'b1, 16'h0000, 8'hFF, 4'b0100, 16'h1111},
      {1'b0, 1'b0, 16'h0000, 8'hFF, 4'b0000, 16'h1111}
   };

   initial begin
      rst_n = 1'b0; push = 1'b0; pop = 1'b0; push_data = '0; bank_in = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 view", {16'd0, stat_view}, 32'h00FF);
      check_flags("R1 flags", 4'b0000);
      check("R1 pop_data", {16'd0, pop_data}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 bank passthrough
      bank_in = 8'hA5;
      #1 check("R2 view", {16'd0, stat_view}, 32'hA5FF);
      @(negedge clk);

      // table: R3 R4 R6 R7 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         apply(v[45], v[44], v[43:28]);
         check($sformatf("R3/R4 vec%0d sp", i), {24'd0, stat_view[7:0]}, {24'd0, v[27:20]});
         check_flags($sformatf("R6/R7 vec%0d flags", i), v[19:16]);
         check($sformatf("R10 vec%0d data", i), {16'd0, pop_data}, {16'd0, v[15:0]});
      end
      check("R2 bank kept", {24'd0, stat_view[15:8]}, 32'hA5);

      // R8 full fill
      for (int i = 0; i < 256; i++) apply(1'b1, 1'b0, 16'h0100 + 16'(i));
      check("R8 sp after fill", {24'd0, stat_view[7:0]}, 32'hFF);
      check_flags("R8 no flag at last push", 4'b0000);
      // R5 push on full
      apply(1'b1, 1'b0, 16'hDEAD);
      check_flags("R5 overflow pulse", 4'b1000);
      check("R5 sp held", {24'd0, stat_view[7:0]}, 32'hFF);
      apply(1'b0, 1'b0, 16'h0);
      check_flags("R5 pulse single", 4'b0000);
      // R8 drain in reverse order
      for (int k = 0; k < 256; k++) begin
         apply(1'b0, 1'b1, 16'h0);
         check("R8 drain data", {16'd0, pop_data}, {16'd0, 16'h0100 + 16'(255 - k)});
         check_flags("R8 drain valid", 4'b0001);
      end
      check("R8 sp after drain", {24'd0, stat_view[7:0]}, 32'hFF);
      apply(1'b0, 1'b1, 16'h0);
      check_flags("R6 underflow after drain", 4'b0100);
      check("R10 data held after underflow", {16'd0, pop_data}, 32'h0100);
      // R7 conflict on empty
      apply(1'b1, 1'b1, 16'h7777);
      check_flags("R7 conflict on empty", 4'b0010);
      apply(1'b0, 1'b1, 16'h0);
      check_flags("R7 nothing written", 4'b0100);

      // R1 reset mid-use
      apply(1'b1, 1'b0, 16'h4444);
      apply(1'b1, 1'b0, 16'h5555);
      apply(1'b0, 1'b0, 16'h0);
      rst_n = 1'b0;
      #1 check("R1 async reset sp", {16'd0, stat_view}, 32'hA5FF);
      @(negedge clk);
      rst_n = 1'b1;
      apply(1'b0, 1'b1, 16'h0);
      check_flags("R1 empty after reset", 4'b0100);
      check("R1 pop_data cleared", {16'd0, pop_data}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule